// File: doc/BRIEF.md
# Clock Mode and Status Controller

This block keeps track of which system clock configuration a microcontroller clock unit is running in and derives the clock enables that the rest of the chip uses. There are two configurations. The first is a PLL mode referenced to the internal 1 MHz oscillator, and it is the one active after reset. The second is a PLL mode referenced to an external oscillator, and it is entered once software sets the oscillator enable. The VCO clock is the block clock. The PLL output clock and the bus clock are not separate clocks: they are single-cycle enables derived from a divide counter.

The block reports an oscillator-ok status. That status can only be true while the PLL is locked. When the spike filter is enabled, the oscillator qualification input must also be high. If lock is lost in external mode, the status drops in the same cycle and the PLL output falls back to a fixed divide-by-four until lock returns.

Every change of lock or of oscillator-ok is recorded in a sticky flag. Software clears these flags by writing a one to them. Each flag has its own interrupt enable, and the enabled flags together drive one interrupt request. The block also selects the clock source for the watchdog and the periodic timer.

Top module: `clkmode_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, ext_mode_o=0, div_ratio_o=3, flags_o=0, irq_o=0, osc_ok_o=0 and bus_ce_o=0.
- R2: pll_ce_o pulses for one cycle every div_ratio_o+1 cycles. With div_ratio_o=3 the first pulse comes on the fourth cycle after reset. bus_ce_o pulses on every second pll_ce_o pulse, starting with the second one after reset.
- R3: ext_mode_o takes the value of osc_en_i one clock later.
- R4: osc_ok_o = pll_lock_i & ext_mode_o & osc_up_i & (~filt_en_i | osc_qual_i). It therefore falls in the same cycle that pll_lock_i falls.
- R5: At a counter wrap (a cycle with pll_ce_o high), div_ratio_o loads 3 if ext_mode_o=1 and pll_lock_i=0, and loads postdiv_i otherwise. In internal mode, therefore, an unlocked PLL keeps the programmed ratio.
- R6: div_ratio_o changes only in the cycle after a pll_ce_o pulse. A postdiv_i change made in the middle of a period does not shorten that period.
- R7: cop_osc_o = ext_mode_o & src_sel_i. In internal mode the watchdog and timer always use the internal reference.
- R8: flags_o[0] is set after any cycle in which pll_lock_i differs from its value in the previous cycle. flags_o[1] is set after any cycle in which osc_ok_o differs from its previous value. The previous values are taken as 0 at reset.
- R9: When clr_we_i=1, each bit of clr_i that is 1 clears the matching flag. A change event in the same cycle takes priority, so the flag stays set. A clear write does not affect the other flags.
- R10: irq_o = |(flags_o & irq_en_i). It stays high until the enabled flags are cleared or their enables are removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock, block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en_i | input | 1 | Oscillator enable; selects external-reference mode |
| pll_lock_i | input | 1 | PLL lock indication |
| osc_up_i | input | 1 | Oscillator start-up complete |
| filt_en_i | input | 1 | Spike filter enabled |
| osc_qual_i | input | 1 | Spike filter qualification |
| postdiv_i | input | DIVW | Programmed post-divider (ratio = value+1) |
| src_sel_i | input | 1 | Watchdog/timer source choice in external mode, 1 = oscillator |
| clr_we_i | input | 1 | Flag clear write strobe |
| clr_i | input | 2 | Write-1-to-clear mask, bit0 lock flag, bit1 osc-ok flag |
| irq_en_i | input | 2 | Interrupt enables per flag |
| ext_mode_o | output | 1 | External-oscillator mode active |
| div_ratio_o | output | DIVW | Effective post-divider in use |
| pll_ce_o | output | 1 | PLL output clock enable |
| bus_ce_o | output | 1 | Bus clock enable |
| osc_ok_o | output | 1 | Oscillator-ok status |
| cop_osc_o | output | 1 | Watchdog/timer clocked from oscillator |
| flags_o | output | 2 | Sticky change flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that oscillator-ok never appears without lock and drops when lock falls. They also check that the ratio holds between wraps, that a wrap in external mode without lock loads divide-by-four, that the bus enable only fires together with a PLL enable, that the source select stays internal outside external mode, and that a flag set but not cleared persists. Some behaviours can only be shown by the bench scenarios, which compare against the reference model: the exact pulse spacing after a mid-period ratio change, the alternation of bus enables, the set-over-clear collision, and the interrupt following the enables.

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl #(
  parameter int DIVW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_en_i,
  input  logic            pll_lock_i,
  input  logic            osc_up_i,
  input  logic            filt_en_i,
  input  logic            osc_qual_i,
  input  logic [DIVW-1:0] postdiv_i,
  input  logic            src_sel_i,
  input  logic            clr_we_i,
  input  logic [1:0]      clr_i,
  input  logic [1:0]      irq_en_i,
  output logic            ext_mode_o,
  output logic [DIVW-1:0] div_ratio_o,
  output logic            pll_ce_o,
  output logic            bus_ce_o,
  output logic            osc_ok_o,
  output logic            cop_osc_o,
  output logic [1:0]      flags_o,
  output logic            irq_o
);
  localparam logic [DIVW-1:0] DIV_DFLT = DIVW'(3);

  logic            mode_q, half_q, lock_q, ok_q;
  logic [DIVW-1:0] cnt_q, div_q, div_next;
  logic [1:0]      flag_q, evt;
  logic            wrap;

  assign osc_ok_o = pll_lock_i & mode_q & osc_up_i & (~filt_en_i | osc_qual_i);
  assign wrap     = (cnt_q == div_q);
  assign div_next = (mode_q & ~pll_lock_i) ? DIV_DFLT : postdiv_i;
  assign evt      = {osc_ok_o ^ ok_q, pll_lock_i ^ lock_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= DIV_DFLT;
      half_q <= 1'b0;
      lock_q <= 1'b0;
      ok_q   <= 1'b0;
      flag_q <= '0;
    end else begin
      mode_q <= osc_en_i;
      lock_q <= pll_lock_i;
      ok_q   <= osc_ok_o;
      if (wrap) begin
        cnt_q  <= '0;
        div_q  <= div_next;
        half_q <= ~half_q;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
      flag_q <= evt | (flag_q & ~({2{clr_we_i}} & clr_i));
    end
  end

  assign ext_mode_o  = mode_q;
  assign div_ratio_o = div_q;
  assign pll_ce_o    = wrap;
  assign bus_ce_o    = wrap & half_q;
  assign cop_osc_o   = mode_q & src_sel_i;
  assign flags_o     = flag_q;
  assign irq_o       = |(flag_q & irq_en_i);
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk #(
  parameter int DIVW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pll_lock_i,
  input logic            src_sel_i,
  input logic            clr_we_i,
  input logic [1:0]      clr_i,
  input logic [1:0]      irq_en_i,
  input logic            ext_mode_o,
  input logic [DIVW-1:0] div_ratio_o,
  input logic            pll_ce_o,
  input logic            bus_ce_o,
  input logic            osc_ok_o,
  input logic            cop_osc_o,
  input logic [1:0]      flags_o,
  input logic            irq_o
);
  // R4
  ok_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_ok_o |-> pll_lock_i);
  // R4
  ok_drops_with_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_lock_i) |-> !osc_ok_o);
  // R6
  ratio_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_ce_o |=> $stable(div_ratio_o));
  // R5
  unlocked_ext_div4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_ce_o && ext_mode_o && !pll_lock_i) |=> (div_ratio_o == DIVW'(3)));
  // R2
  bus_inside_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce_o |-> pll_ce_o);
  // R7
  internal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode_o |-> !cop_osc_o);
  // R9
  lock_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[0] && !(clr_we_i && clr_i[0])) |=> flags_o[0]);
  // R10
  irq_on_enabled_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_o & irq_en_i)) |-> irq_o);
  // R7
  ext_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode_o && src_sel_i) |-> cop_osc_o);
endmodule

bind clkmode_ctrl clkmode_ctrl_chk #(.DIVW(DIVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_lock_i(pll_lock_i), .src_sel_i(src_sel_i),
  .clr_we_i(clr_we_i), .clr_i(clr_i), .irq_en_i(irq_en_i),
  .ext_mode_o(ext_mode_o), .div_ratio_o(div_ratio_o), .pll_ce_o(pll_ce_o),
  .bus_ce_o(bus_ce_o), .osc_ok_o(osc_ok_o), .cop_osc_o(cop_osc_o),
  .flags_o(flags_o), .irq_o(irq_o)
);

// File: tb/clkmode_ctrl_test.sv
`timescale 1ns/1ps
module clkmode_ctrl_test;
  localparam int DIVW = 5;

  logic clk = 0, rst_n = 0;
  logic osc_en = 0, lock = 0, up = 0, filt = 0, qual = 0, src = 0, we = 0;
  logic [DIVW-1:0] pdiv = 5'd3;
  logic [1:0] clr = 0, ien = 0;
  logic ext, pce, bce, ok, cop, irq;
  logic [DIVW-1:0] div;
  logic [1:0] flg;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clkmode_ctrl #(.DIVW(DIVW)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en_i(osc_en), .pll_lock_i(lock),
    .osc_up_i(up), .filt_en_i(filt), .osc_qual_i(qual), .postdiv_i(pdiv),
    .src_sel_i(src), .clr_we_i(we), .clr_i(clr), .irq_en_i(ien),
    .ext_mode_o(ext), .div_ratio_o(div), .pll_ce_o(pce), .bus_ce_o(bce),
    .osc_ok_o(ok), .cop_osc_o(cop), .flags_o(flg), .irq_o(irq));

  // behavioural reference model
  int m_mode, m_cnt, m_div, m_pulses, m_lock_prev, m_ok_prev;
  int m_flag[2];

  function automatic int exp_ok();
    return (lock && m_mode && up && (!filt || qual)) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_div = 3; m_pulses = 0;
      m_lock_prev = 0; m_ok_prev = 0; m_flag[0] = 0; m_flag[1] = 0;
    end else begin
      int okn, ev[2];
      okn = exp_ok();
      ev[0] = (int'(lock) != m_lock_prev);
      ev[1] = (okn != m_ok_prev);
      for (int i = 0; i < 2; i++)
        if (ev[i] != 0) m_flag[i] = 1;
        else if (we && clr[i]) m_flag[i] = 0;
      if (m_cnt == m_div) begin
        m_cnt = 0;
        m_pulses++;
        m_div = (m_mode != 0 && !lock) ? 3 : int'(pdiv);
      end else m_cnt++;
      m_mode = osc_en;
      m_lock_prev = lock;
      m_ok_prev = okn;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    int ep, eflags, eirq;
    ep = (m_cnt == m_div) ? 1 : 0;
    eflags = m_flag[1] * 2 + m_flag[0];
    eirq = ((eflags & int'(ien)) != 0) ? 1 : 0;
    chk("R3", "ext_mode", ext, m_mode);
    chk("R5/R6", "div_ratio", div, m_div);
    chk("R2", "pll_ce", pce, ep);
    chk("R2", "bus_ce", bce, (ep && (m_pulses % 2 == 1)) ? 1 : 0);
    chk("R4", "osc_ok", ok, exp_ok());
    chk("R7", "cop_osc", cop, (m_mode != 0 && src) ? 1 : 0);
    chk("R8/R9", "flags", flg, eflags);
    chk("R10", "irq", irq, eirq);
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset values
    chk("R1", "ext_mode rst", ext, 0); chk("R1", "div rst", div, 3);
    chk("R1", "flags rst", flg, 0);    chk("R1", "irq rst", irq, 0);
    chk("R1", "osc_ok rst", ok, 0);    chk("R1", "bus_ce rst", bce, 0);
    rst_n = 1;
    tick(20);
    // R6 mid-period ratio change
    tick(1); pdiv = 1; tick(12); pdiv = 6; tick(2); pdiv = 0; tick(15);
    // R5 internal mode with lock low keeps ratio
    pdiv = 2; tick(10);
    lock = 1; tick(5); ien = 2'b01; tick(3);
    we = 1; clr = 2'b01; tick(1); we = 0; clr = 0; tick(3);
    // R3 enter external mode, R4 osc ok
    osc_en = 1; src = 1; up = 1; tick(6);
    filt = 1; qual = 0; tick(4); qual = 1; tick(4);
    ien = 2'b10; tick(2);
    // R9 clear collides with event
    we = 1; clr = 2'b11; lock = 0; tick(1); we = 0; clr = 0; tick(20);
    // R5 relock returns to programmed ratio
    lock = 1; tick(20);
    we = 1; clr = 2'b11; tick(1); we = 0; clr = 0; tick(4);
    src = 0; tick(3); osc_en = 0; src = 1; tick(5);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      osc_en = ($urandom % 16) != 0 ? osc_en : ~osc_en;
      lock   = ($urandom % 8) != 0 ? lock : ~lock;
      up = $urandom; filt = $urandom; qual = $urandom; src = $urandom;
      if ($urandom % 10 == 0) pdiv = $urandom % 8;
      we = ($urandom % 4 == 0); clr = $urandom; ien = $urandom;
      tick(1);
    end
    we = 0;
    tick(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule